// File: doc/BRIEF.md
# Branch and Next-PC Unit with One Delay Slot

This block decides where a 32-bit RISC core fetches next. Each advancing instruction brings its own PC, two register operands, a 16-bit branch displacement, a 26-bit direct jump field and a transfer-kind code. The block evaluates the branch condition straight from the operand values, since the core has no condition flags. It forms the candidate target and reports whether the transfer is taken.

A taken transfer does not redirect fetch at once. The instruction that follows the branch or jump, called the delay slot, always runs. The block holds the target in a register and presents it as the next PC once that slot instruction advances. A jump-and-link also produces a write enable and a return address for register 31.

Top module: `nextpc_ctl`

## Requirements
- R1: After reset no redirect is pending. An advancing non-transfer instruction (kind 0) yields next_pc = pc_cur + 4, taken = 0 and link_we = 0.
- R2: Kind 1 (equal) is taken when rs_val equals rt_val. Kind 2 (not equal) is taken when they differ.
- R3: Kinds 3, 4, 5 and 6 test rs_val as a signed two's-complement number against zero: <= 0, > 0, < 0 and >= 0 respectively. rt_val is ignored for these kinds.
- R4: A conditional branch target is pc_cur + 4 + (sign-extended offs16 shifted left by 2).
- R5: Kind 7 (direct jump) is always taken. Its target is bits 31:28 of pc_cur + 4, then jtarget, then two zero bits.
- R6: Kind 8 (register jump) is always taken and its target is rs_val.
- R7: Kind 9 (jump and link) is always taken, with the same target as kind 7. In the same cycle it asserts link_we with link_val = pc_cur + 8, which is the address after the delay slot.
- R8: While a transfer is advancing, next_pc is still pc_cur + 4, so the delay-slot instruction is fetched in every case.
- R9: Once a taken transfer has advanced, next_pc equals its target until the next advancing instruction (the delay slot) is accepted. After that instruction, sequential flow resumes.
- R10: Cycles with adv low leave a pending redirect unchanged and assert neither taken nor link_we. A not-taken branch leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv | input | 1 | Current instruction advances this cycle |
| kind | input | 4 | Transfer kind code (0 none, 1..9 as in the requirements) |
| pc_cur | input | 32 | Address of the current instruction |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| offs16 | input | 16 | Branch displacement in instructions |
| jtarget | input | 26 | Direct jump word field |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Current advancing instruction is a taken transfer |
| link_we | output | 1 | Write link_val to register 31 |
| link_val | output | 32 | Return address for the link write |

## Verification
A lost or stale pending redirect shows on next_pc in the very cycle of the delay slot. A dropped target sends fetch to pc+8, and a redirect that is never cleared sends a second instruction to the old target one advance later. A wrong condition or target term shows on taken in the cycle the branch is presented, and on next_pc one advance later. Stall cycles between the branch and its slot show whether the held target survives without being consumed.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [3:0] {
      XF_NONE = 4'd0,
      XF_EQ   = 4'd1,
      XF_NE   = 4'd2,
      XF_LEZ  = 4'd3,
      XF_GTZ  = 4'd4,
      XF_LTZ  = 4'd5,
      XF_GEZ  = 4'd6,
      XF_JMP  = 4'd7,
      XF_JREG = 4'd8,
      XF_JLNK = 4'd9
   } xfer_e;

   localparam int unsigned INSN_BYTES = 4;
   localparam int unsigned INSN_SHIFT = 2;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  xfer_e           kind_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            take_o
);
   logic a_neg, a_zero, ab_eq;

   assign a_neg  = a_i[XLEN-1];
   assign a_zero = (a_i == '0);
   assign ab_eq  = (a_i == b_i);

   always_comb begin
      unique case (kind_i)
         XF_EQ:   take_o = ab_eq;
         XF_NE:   take_o = !ab_eq;
         XF_LEZ:  take_o = a_neg || a_zero;
         XF_GTZ:  take_o = !a_neg && !a_zero;
         XF_LTZ:  take_o = a_neg;
         XF_GEZ:  take_o = !a_neg;
         XF_JMP, XF_JREG, XF_JLNK: take_o = 1'b1;
         default: take_o = 1'b0;
      endcase
   end

   // R1
   none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == XF_NONE) |-> !take_o);

   // R5
   uncond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i inside {XF_JMP, XF_JREG, XF_JLNK}) |-> take_o);

   // R3
   sign_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == XF_LTZ && take_o) |-> !a_zero);
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned OFFS_W = 16,
   parameter int unsigned JT_W   = 26
) (
   input  xfer_e             kind_i,
   input  logic [XLEN-1:0]   seq_pc_i,
   input  logic [XLEN-1:0]   reg_i,
   input  logic [OFFS_W-1:0] offs_i,
   input  logic [JT_W-1:0]   jt_i,
   output logic [XLEN-1:0]   tgt_o
);
   localparam int unsigned REGION_W = XLEN - JT_W - INSN_SHIFT;

   logic [XLEN-1:0] br_disp, br_tgt, jmp_tgt;

   generate
      if (XLEN < OFFS_W + INSN_SHIFT) begin : g_bad_offs
         $error("npc_target: XLEN too narrow for offset");
      end
      if (REGION_W == 0) begin : g_flat
         assign jmp_tgt = {jt_i, {INSN_SHIFT{1'b0}}};
      end else begin : g_region
         assign jmp_tgt = {seq_pc_i[XLEN-1 -: REGION_W], jt_i, {INSN_SHIFT{1'b0}}};
      end
   endgenerate

   assign br_disp = {{(XLEN-OFFS_W-INSN_SHIFT){offs_i[OFFS_W-1]}}, offs_i, {INSN_SHIFT{1'b0}}};
   assign br_tgt  = seq_pc_i + br_disp;

   always_comb begin
      unique case (kind_i)
         XF_JMP, XF_JLNK: tgt_o = jmp_tgt;
         XF_JREG:         tgt_o = reg_i;
         default:         tgt_o = br_tgt;
      endcase
   end
endmodule

// File: rtl/npc_slot.sv
module npc_slot #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   input  logic            take_i,
   input  logic [XLEN-1:0] tgt_i,
   input  logic [XLEN-1:0] seq_pc_i,
   output logic [XLEN-1:0] next_pc_o
);
   logic            pend_q;
   logic [XLEN-1:0] pend_tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_tgt_q <= '0;
      end else if (adv_i) begin
         pend_q <= take_i;
         if (take_i) pend_tgt_q <= tgt_i;
      end
   end

   assign next_pc_o = pend_q ? pend_tgt_q : seq_pc_i;

   // R9
   slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && take_i) |=> (next_pc_o == $past(tgt_i)));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !adv_i) |=> (pend_q && $stable(pend_tgt_q)));

   // R9
   consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && adv_i && !take_i) |=> !pend_q);
endmodule

// File: rtl/nextpc_ctl.sv
module nextpc_ctl
   import npc_pkg::*;
#(
   parameter int unsigned XLEN            = 32,
   parameter int unsigned OFFS_W          = 16,
   parameter int unsigned JT_W            = 26,
   parameter bit          LINK_AFTER_SLOT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [3:0]      kind,
   input  logic [XLEN-1:0] pc_cur,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   input  logic [OFFS_W-1:0] offs16,
   input  logic [JT_W-1:0] jtarget,
   output logic [XLEN-1:0] next_pc,
   output logic            taken,
   output logic            link_we,
   output logic [XLEN-1:0] link_val
);
   localparam int unsigned LINK_STEP = LINK_AFTER_SLOT ? 2*INSN_BYTES : INSN_BYTES;

   generate
      if (XLEN < JT_W + INSN_SHIFT) begin : g_bad_xlen
         $error("nextpc_ctl: XLEN cannot hold the jump field");
      end
   endgenerate

   xfer_e           kind_e;
   logic [XLEN-1:0] seq_pc, tgt;
   logic            take;

   assign kind_e = xfer_e'(kind);
   assign seq_pc = pc_cur + XLEN'(INSN_BYTES);

   npc_cond #(.XLEN(XLEN)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind_i (kind_e),
      .a_i    (rs_val),
      .b_i    (rt_val),
      .take_o (take)
   );

   npc_target #(.XLEN(XLEN), .OFFS_W(OFFS_W), .JT_W(JT_W)) u_tgt (
      .kind_i   (kind_e),
      .seq_pc_i (seq_pc),
      .reg_i    (rs_val),
      .offs_i   (offs16),
      .jt_i     (jtarget),
      .tgt_o    (tgt)
   );

   npc_slot #(.XLEN(XLEN)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (adv),
      .take_i    (take),
      .tgt_i     (tgt),
      .seq_pc_i  (seq_pc),
      .next_pc_o (next_pc)
   );

   assign taken    = adv && take;
   assign link_we  = adv && (kind_e == XF_JLNK);
   assign link_val = pc_cur + XLEN'(LINK_STEP);

   // R7
   link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> taken);

   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |-> (!taken && !link_we));
endmodule

// File: tb/nextpc_ctl_tb.sv
module nextpc_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv;
   logic [3:0]  kind;
   logic [31:0] pc_cur, rs_val, rt_val;
   logic [15:0] offs16;
   logic [25:0] jtarget;
   logic [31:0] next_pc, link_val;
   logic        taken, link_we;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   nextpc_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .pc_cur(pc_cur),
      .rs_val(rs_val), .rt_val(rt_val), .offs16(offs16), .jtarget(jtarget),
      .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_val(link_val)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic a, input logic [3:0] k, input logic [31:0] pc,
                        input logic [31:0] rs, input logic [31:0] rt,
                        input logic [15:0] off, input logic [25:0] jt);
      @(negedge clk);
      adv = a; kind = k; pc_cur = pc; rs_val = rs; rt_val = rt; offs16 = off; jtarget = jt;
      #1;
   endtask

   // transfer, then delay slot; checks taken, slot fetch and redirect
   task automatic xfer(input string req, input logic [3:0] k, input logic [31:0] pc,
                       input logic [31:0] rs, input logic [31:0] rt, input logic [15:0] off,
                       input logic [25:0] jt, input bit exp_tk, input logic [31:0] exp_tgt);
      drive(1'b1, k, pc, rs, rt, off, jt);
      chk(taken == exp_tk, req, {31'd0, taken}, {31'd0, exp_tk});
      chk(next_pc == pc + 32'd4, {req, "/R8"}, next_pc, pc + 32'd4);
      drive(1'b1, 4'd0, pc + 32'd4, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(next_pc == (exp_tk ? exp_tgt : pc + 32'd8), {req, "/R9"}, next_pc,
          exp_tk ? exp_tgt : pc + 32'd8);
      drive(1'b1, 4'd0, 32'h0000_4000, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(next_pc == 32'h0000_4004, {req, "/R9 resume"}, next_pc, 32'h0000_4004);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      adv = 1'b0; kind = 4'd0; pc_cur = 32'h100; rs_val = 0; rt_val = 0; offs16 = 0; jtarget = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      drive(1'b1, 4'd0, 32'h0000_0100, 32'd5, 32'd5, 16'd0, 26'd0);
      chk(next_pc == 32'h104, "R1", next_pc, 32'h104);
      chk(!taken && !link_we, "R1", {30'd0, taken, link_we}, 32'd0);
   endtask

   task automatic t_eq_ne();
      xfer("R2 eq hit",  4'd1, 32'h1000, 32'h55, 32'h55, 16'h0010, 26'd0, 1'b1, 32'h1044);
      xfer("R2 eq miss", 4'd1, 32'h1000, 32'h55, 32'h56, 16'h0010, 26'd0, 1'b0, 32'h0);
      xfer("R2 ne hit",  4'd2, 32'h2000, 32'h1,  32'h2,  16'h0002, 26'd0, 1'b1, 32'h200C);
      xfer("R2 ne miss", 4'd2, 32'h2000, 32'h7,  32'h7,  16'h0002, 26'd0, 1'b0, 32'h0);
   endtask

   task automatic t_sign();
      logic [31:0] vals [3];
      vals[0] = 32'hFFFF_FFFF; vals[1] = 32'h0; vals[2] = 32'h1;
      for (int k = 3; k <= 6; k++) begin
         for (int i = 0; i < 3; i++) begin
            int sv;
            bit e;
            sv = $signed(vals[i]);
            case (k)
               3: e = (sv <= 0);
               4: e = (sv > 0);
               5: e = (sv < 0);
               default: e = (sv >= 0);
            endcase
            // R3: rt_val set to rs_val-like junk to show it is ignored
            xfer("R3", 4'(k), 32'h3000, vals[i], 32'hDEAD_BEEF, 16'h0004, 26'd0, e, 32'h3014);
         end
      end
   endtask

   task automatic t_neg_offset();
      // R4: offset -4 instructions from pc+4
      xfer("R4 neg", 4'd1, 32'h0000_8000, 32'd0, 32'd0, 16'hFFFC, 26'd0, 1'b1, 32'h0000_7FF4);
      xfer("R4 max", 4'd6, 32'h0001_0000, 32'd3, 32'd0, 16'h7FFF, 26'd0, 1'b1, 32'h0003_0000);
   endtask

   task automatic t_jumps();
      xfer("R5 j", 4'd7, 32'hA000_0010, 32'd0, 32'd0, 16'd0, 26'h0123456, 1'b1, 32'hA048_D158);
      // R5: region bits come from pc+4, which crosses into the next region
      xfer("R5 region", 4'd7, 32'h1FFF_FFFC, 32'd0, 32'd0, 16'd0, 26'h0000001, 1'b1, 32'h2000_0004);
      xfer("R6 jr", 4'd8, 32'h0000_5000, 32'hCAFE_0040, 32'd0, 16'h1234, 26'h3FFFFFF, 1'b1, 32'hCAFE_0040);
   endtask

   task automatic t_link();
      drive(1'b1, 4'd9, 32'h4000_0200, 32'd0, 32'd0, 16'd0, 26'h0000040);
      chk(link_we == 1'b1, "R7 we", {31'd0, link_we}, 32'd1);
      chk(link_val == 32'h4000_0208, "R7 val", link_val, 32'h4000_0208);
      drive(1'b1, 4'd0, 32'h4000_0204, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(!link_we, "R7 slot", {31'd0, link_we}, 32'd0);
      chk(next_pc == 32'h4000_0100, "R7 tgt", next_pc, 32'h4000_0100);
      drive(1'b1, 4'd0, 32'h4000_0100, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(next_pc == 32'h4000_0104, "R7 resume", next_pc, 32'h4000_0104);
   endtask

   task automatic t_stall();
      drive(1'b1, 4'd8, 32'h6000, 32'h0000_9990, 32'd0, 16'd0, 26'd0);
      drive(1'b0, 4'd9, 32'h6004, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(!taken && !link_we, "R10 idle", {30'd0, taken, link_we}, 32'd0);
      chk(next_pc == 32'h9990, "R10 hold", next_pc, 32'h9990);
      drive(1'b0, 4'd0, 32'h6004, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(next_pc == 32'h9990, "R10 hold2", next_pc, 32'h9990);
      drive(1'b1, 4'd0, 32'h6004, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(next_pc == 32'h9990, "R10 slot", next_pc, 32'h9990);
      drive(1'b1, 4'd0, 32'h9990, 32'd0, 32'd0, 16'd0, 26'd0);
      chk(next_pc == 32'h9994, "R10 clear", next_pc, 32'h9994);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_eq_ne();
            t_sign();
            t_neg_offset();
            t_jumps();
            t_link();
            t_stall();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule